// File: doc/BRIEF.md
# Status Word and Write-Permission Guard

This block keeps the eight-bit status word of a serial non-volatile memory and decides whether a write can start. A command front end sends it one-cycle decoded strobes: enable writes, disable writes, write the status word together with its data byte, write the array together with the target byte address, and a completion strobe when the internal write cycle ends. The block also samples the active-low write-protect pin.

Its outputs are the status byte, returned on a status read, and two single-cycle grants: one for an array write and one for a status write. A write is granted only when the write-enable latch is set and no cycle is running. An array write is also refused when its address lies in the region that the two protection bits select. A status write is also refused while the hardware lock is active, which means the stored lock bit is 1 and the pin is low.

The non-volatile bits are plain flops with a reset value. A granted status write captures its data when it is granted and commits that data when the completion strobe arrives.

Top module: `status_guard`

## Requirements
- R1: After reset, the status byte reads 0x00.
- R2: The status byte holds the lock bit in bit 7, zeros in bits 6 to 4, the region code in bits 3:2, the write-enable latch in bit 1 and the busy flag in bit 0. Bits 6 to 4 read 0 whatever data byte was written.
- R3: While idle, the enable strobe sets the latch (bit 1) and the disable strobe clears it, each visible from the cycle after the strobe.
- R4: An array-write strobe raises `grant_array` in the same cycle only if the latch is 1, no cycle is busy and the address is outside the protected region. Otherwise `grant_array` stays 0.
- R5: For a 13-bit address, the region codes protect these ranges: 00 protects nothing, 01 protects 0x1800 to 0x1FFF, 10 protects 0x1000 to 0x1FFF, and 11 protects the whole array.
- R6: A refused array write leaves the latch at 1 and the busy flag at 0.
- R7: After any grant, bit 0 reads 1 from the next cycle. Bit 1 stays 1 until the completion strobe. From the cycle after the completion strobe, both bits read 0.
- R8: A status-write strobe raises `grant_status` in the same cycle only if the latch is 1, no cycle is busy, and not (bit 7 = 1 and `wp_n` = 0). A refused status write changes no bit of the status byte.
- R9: A granted status write copies data bits 7, 3 and 2 into status bits 7, 3 and 2 at the completion strobe. Before that strobe, the old values still read back.
- R10: While busy, the enable, disable, status-write and array-write strobes produce no grant and change no status bit. The status byte stays readable and shows the live busy and latch values.
- R11: With bit 7 at 0, a low `wp_n` does not block status writes.
- R12: A completion strobe while idle changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Enable-writes strobe |
| cmd_wrdi | input | 1 | Disable-writes strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_write | input | 1 | Array-write strobe |
| write_addr | input | ADDR_W | Target byte address of the array write |
| write_done | input | 1 | End of the internal write cycle |
| wp_n | input | 1 | Write-protect pin, active low |
| status_byte | output | 8 | Live status word |
| grant_array | output | 1 | Array write accepted (same cycle as strobe) |
| grant_status | output | 1 | Status write accepted (same cycle as strobe) |

## Verification
The hardest state to reach is a strobe that arrives while a cycle is busy. At that point the latch is already set and the region and lock checks alone would grant the write. The stimulus therefore starts an unprotected array write and holds back the completion strobe. During that gap it sends every other command and reads the status byte after each one. The hardware lock needs its own sequence: the lock bit is first committed with the pin high, and only then is the pin driven low for a second status write. Each of the four region codes is loaded in turn, and array writes then sweep the whole address space with a coarse step plus the addresses on both sides of each region boundary.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;

    typedef struct packed {
        logic       lock;
        logic [1:0] region;
    } nv_word_t;

    localparam nv_word_t NV_CLEAR = '{lock: 1'b0, region: 2'b00};

    function automatic logic [7:0] pack_status(nv_word_t nv, logic latch, logic busy);
        return {nv.lock, 3'b000, nv.region, latch, busy};
    endfunction

    function automatic nv_word_t unpack_nv(logic [7:0] data);
        return '{lock: data[7], region: data[3:2]};
    endfunction

endpackage

// File: rtl/status_region_check.sv
module status_region_check #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        region,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [1:0] top2;
    assign top2 = addr[ADDR_W-1 -: 2];

    always_comb begin
        unique case (region)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top2 == 2'b11);
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
    end

    always_comb begin
        if (region == 2'b00) assert_no_hit_open_R5: assert (!hit);
    end
endmodule

// File: rtl/status_cycle_ctrl.sv
module status_cycle_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_latch,
    input  logic clr_latch,
    input  logic start_array,
    input  logic start_status,
    input  logic done,
    output logic busy,
    output logic latch,
    output logic commit_status
);
    logic busy_q, latch_q, kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            latch_q <= 1'b0;
            kind_q  <= 1'b0;
        end else if (busy_q) begin
            if (done) begin
                busy_q  <= 1'b0;
                latch_q <= 1'b0;
            end
        end else if (start_array || start_status) begin
            busy_q <= 1'b1;
            kind_q <= start_status;
        end else if (clr_latch) begin
            latch_q <= 1'b0;
        end else if (set_latch) begin
            latch_q <= 1'b1;
        end
    end

    assign busy          = busy_q;
    assign latch         = latch_q;
    assign commit_status = busy_q && done && kind_q;

    assert_done_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && done) |=> (!busy_q && !latch_q));
    assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && (start_array || start_status)) |=> busy_q);
    assert_busy_holds_latch_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> ($stable(latch_q) && busy_q));
endmodule

// File: rtl/status_nv_regs.sv
module status_nv_regs
    import status_guard_pkg::*;
#(
    parameter nv_word_t RST_NV = NV_CLEAR
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     capture,
    input  nv_word_t capture_val,
    input  logic     commit,
    output nv_word_t nv
);
    nv_word_t nv_q, pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q   <= RST_NV;
            pend_q <= RST_NV;
        end else begin
            if (capture) pend_q <= capture_val;
            if (commit)  nv_q   <= pend_q;
        end
    end

    assign nv = nv_q;

    assert_nv_only_on_commit_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(nv_q));
endmodule

// File: rtl/status_guard.sv
module status_guard
    import status_guard_pkg::*;
#(
    parameter int       ADDR_W = 13,
    parameter nv_word_t RST_NV = NV_CLEAR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] write_addr,
    input  logic              write_done,
    input  logic              wp_n,
    output logic [7:0]        status_byte,
    output logic              grant_array,
    output logic              grant_status
);
    nv_word_t nv;
    logic busy, latch, commit_status, in_region, hw_locked, may_start;

    status_region_check #(.ADDR_W(ADDR_W)) u_region (
        .region (nv.region),
        .addr   (write_addr),
        .hit    (in_region)
    );

    assign hw_locked    = nv.lock && !wp_n;
    assign may_start    = latch && !busy;
    assign grant_array  = cmd_write && may_start && !in_region;
    assign grant_status = cmd_wrsr && may_start && !hw_locked && !cmd_write;

    status_cycle_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .set_latch     (cmd_wren),
        .clr_latch     (cmd_wrdi),
        .start_array   (grant_array),
        .start_status  (grant_status),
        .done          (write_done),
        .busy          (busy),
        .latch         (latch),
        .commit_status (commit_status)
    );

    status_nv_regs #(.RST_NV(RST_NV)) u_nv (
        .clk         (clk),
        .rst         (rst),
        .capture     (grant_status),
        .capture_val (unpack_nv(wrsr_data)),
        .commit      (commit_status),
        .nv          (nv)
    );

    assign status_byte = pack_status(nv, latch, busy);

    assert_grant_needs_latch_R4: assert property (@(posedge clk) disable iff (rst)
        grant_array |-> (status_byte[1] && !status_byte[0]));
    assert_no_grant_in_region_R4: assert property (@(posedge clk) disable iff (rst)
        (status_byte[3:2] == 2'b11) |-> !grant_array);
    assert_hw_lock_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (status_byte[7] && !wp_n) |-> !grant_status);
    assert_refused_keeps_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_write && !grant_array && !cmd_wrsr && !cmd_wrdi && status_byte[1]) |=> status_byte[1]);
endmodule

// File: tb/status_guard_test.sv
`timescale 1ns/1ps
module status_guard_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, write_done = 0, wp_n = 1;
    logic [7:0] wrsr_data = 8'h00;
    logic [12:0] write_addr = '0;
    logic [7:0] status_byte;
    logic grant_array, grant_status;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    status_guard uut (
        .clk(clk), .rst(rst), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_write(cmd_write),
        .write_addr(write_addr), .write_done(write_done), .wp_n(wp_n),
        .status_byte(status_byte), .grant_array(grant_array), .grant_status(grant_status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic pulse_wren();
        @(negedge clk) cmd_wren = 1; @(negedge clk) cmd_wren = 0;
    endtask
    task automatic pulse_wrdi();
        @(negedge clk) cmd_wrdi = 1; @(negedge clk) cmd_wrdi = 0;
    endtask
    task automatic pulse_done();
        @(negedge clk) write_done = 1; @(negedge clk) write_done = 0;
    endtask
    task automatic try_wrsr(input logic [7:0] d, output logic g);
        @(negedge clk) cmd_wrsr = 1; wrsr_data = d;
        #2 g = grant_status;
        @(negedge clk) cmd_wrsr = 0;
    endtask
    task automatic try_write(input logic [12:0] a, output logic g);
        @(negedge clk) cmd_write = 1; write_addr = a;
        #2 g = grant_array;
        @(negedge clk) cmd_write = 0;
    endtask

    function automatic logic prot(input logic [1:0] bp, input int a);
        case (bp)
            2'd0: return 1'b0;
            2'd1: return a >= 6144;
            2'd2: return a >= 4096;
            default: return 1'b1;
        endcase
    endfunction

    task automatic load_status(input logic [7:0] d);
        logic g;
        pulse_wren();
        try_wrsr(d, g);
        pulse_done();
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic g;
        logic [7:0] nvb;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset value", status_byte, 8'h00);

        // R3 latch set/clear
        pulse_wren();
        chk("R3 enable sets bit1", status_byte, 8'h02);
        pulse_wrdi();
        chk("R3 disable clears bit1", status_byte, 8'h00);

        // R4 without latch
        try_write(13'h0000, g);
        chk("R4 no grant without latch", {7'd0, g}, 8'h00);
        try_wrsr(8'h8C, g);
        chk("R8 no status grant without latch", {7'd0, g}, 8'h00);

        // R12 done while idle
        pulse_wren();
        pulse_done();
        chk("R12 idle completion ignored", status_byte, 8'h02);
        pulse_wrdi();

        // R2/R9: ignored data bits, commit at completion
        pulse_wren();
        try_wrsr(8'h7F, g);
        chk("R8 status grant", {7'd0, g}, 8'h01);
        chk("R9 old bits before completion, R7 busy", status_byte, 8'h03);
        pulse_done();
        chk("R2 bits 6..4 zero, R9 commit", status_byte, 8'h0C);
        load_status(8'h73);
        chk("R9 commit clears bits", status_byte, 8'h00);

        // R5/R4/R6/R7 sweep over region codes and addresses
        for (int bp = 0; bp < 4; bp++) begin
            load_status({4'b0, bp[1:0], 2'b00});
            nvb = {4'b0, bp[1:0], 2'b00};
            for (int i = 0; i < 72; i++) begin
                int a;
                logic e;
                if (i < 64) a = i * 128;
                else case (i)
                    64: a = 4095; 65: a = 4096; 66: a = 6143; 67: a = 6144;
                    68: a = 8191; 69: a = 1;    70: a = 6145; default: a = 4097;
                endcase
                e = !prot(bp[1:0], a);
                pulse_wren();
                try_write(a[12:0], g);
                chk($sformatf("R5 R4 grant bp=%0d addr=%0h", bp, a), {7'd0, g}, {7'd0, e});
                if (e) begin
                    chk("R7 busy and latch during cycle", status_byte, nvb | 8'h03);
                    pulse_done();
                    chk("R7 both clear after completion", status_byte, nvb);
                end else begin
                    chk("R6 refused keeps latch, not busy", status_byte, nvb | 8'h02);
                    pulse_wrdi();
                end
            end
        end
        load_status(8'h00);

        // R10 strobes while busy
        pulse_wren();
        try_write(13'h0010, g);
        pulse_wrdi();
        chk("R10 disable ignored while busy", status_byte, 8'h03);
        try_wrsr(8'h8C, g);
        chk("R10 status grant blocked while busy", {7'd0, g}, 8'h00);
        try_write(13'h0020, g);
        chk("R10 array grant blocked while busy", {7'd0, g}, 8'h00);
        pulse_wren();
        chk("R10 status readable while busy", status_byte, 8'h03);
        pulse_done();
        chk("R10 busy wrsr never committed", status_byte, 8'h00);

        // R8 hardware lock
        load_status(8'h84);
        chk("R8 lock bit stored", status_byte, 8'h84);
        @(negedge clk) wp_n = 0;
        pulse_wren();
        try_wrsr(8'h00, g);
        chk("R8 lock refuses status grant", {7'd0, g}, 8'h00);
        chk("R8 refused status write keeps bits", status_byte, 8'h86);
        @(negedge clk) wp_n = 1;
        try_wrsr(8'h00, g);
        chk("R8 pin high allows status grant", {7'd0, g}, 8'h01);
        pulse_done();
        chk("R8 unlocked commit", status_byte, 8'h00);

        // R11 pin low with lock bit clear
        @(negedge clk) wp_n = 0;
        pulse_wren();
        try_wrsr(8'h88, g);
        chk("R11 pin ignored without lock bit", {7'd0, g}, 8'h01);
        pulse_done();
        chk("R11 commit with pin low", status_byte, 8'h88);
        try_wrsr(8'h00, g);
        chk("R8 latch cleared after completion blocks", {7'd0, g}, 8'h00);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule